// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block counts activity on one external input into an 8-bit register. In event-count mode every selected transition of the input adds one. In gated-time mode a free-running tick, one bus clock in 64, adds one whenever the input sits at its active level. A single polarity bit serves both modes. In event mode it picks the counted edge direction. In gated mode it picks which input level inhibits counting.

Software reaches the block through a small register port with four addresses:

| Address | Contents |
|---|---|
| 0 | Control: bit0 enable, bit1 mode (0 event, 1 gated), bit2 polarity |
| 1 | Count |
| 2 | Flags: bit0 wrap, bit1 edge |
| 3 | Interrupt enables: bit0 wrap, bit1 edge |

The interrupt request is the OR of every flag whose enable bit is set. The count register has no reset, so its value survives a reset.

A three-state controller decides the behaviour:

- **ST_OFF**: nothing counts and no flag is set.
- **ST_EVENT**: selected edges count.
- **ST_GATED**: ticks count while the input is at its active level.

Its transitions are named as follows. DISABLE goes from any state to ST_OFF when enable is 0. ARM_EVENT goes to ST_EVENT when enable is 1 and mode is 0. ARM_GATED goes to ST_GATED when enable is 1 and mode is 1. The state follows the control register one clock after a write. Reset forces ST_OFF.

Top module: `evt_accum`

## Requirements
- R1: After reset the control, flag and enable registers read 0x00 and `irq` is low.
- R2: Reset does not change the count register. A value written before reset reads back unchanged after it.
- R3: In event mode, with polarity 0 each rising input edge adds one to the count, and with polarity 1 each falling edge adds one. The other edge direction adds nothing. A count change is visible three clocks after the input changes, because of two synchronizer stages and the count register.
- R4: In gated mode a tick occurs once every 64 clocks. The tick adds one to the count while the input is active. Polarity 0 makes a high input active and a low input inhibiting. Polarity 1 makes a low input active. Any 64·k consecutive active clocks give exactly k increments.
- R5: With enable 0 the count does not change and no flag is set, whatever the input does.
- R6: When an increment takes the count from 0xFF to 0x00, the wrap flag (bit0) is set.
- R7: In either mode, the edge flag (bit1) is set on the edge that the polarity selects: rising for polarity 0, falling for polarity 1.
- R8: Writing a 1 to a flag bit clears that bit. Writing a 0 leaves it unchanged.
- R9: `irq` is high exactly when some flag bit and its enable bit are both 1. Writing the enable register never changes the flags.
- R10: A write to the count register wins over an increment in the same clock. The written value is stored, and the wrap flag is not set by that increment.
- R11: An input that toggles on every clock is counted in full: one increment for every selected edge, which is one every two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External input, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a software write to the count register in the same clock as a hardware increment, above all when the count holds 0xFF, because the bus and the synchronized pin must line up to the cycle. The stimulus drives a single input edge and waits one clock. It then issues the count write, so the write strobe lands on the clock where the increment would commit. Gated-mode counts are made exact by holding the input active for whole multiples of 64 clocks. That cancels the unknown phase of the tick divider.

// File: rtl/evt_accum_pkg.sv
package evt_accum_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_FLG  = 2'd2;
    localparam logic [1:0] ADDR_IEN  = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_MODE = 1;
    localparam int CTL_POL  = 2;

    localparam int FLG_WRAP = 0;
    localparam int FLG_EDGE = 1;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EVENT = 2'd1,
        ST_GATED = 2'd2
    } acc_state_t;
endpackage

// File: rtl/evt_accum_sync.sv
module evt_accum_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    if (i == 0) chain_q[i] <= d_async;
                    else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/evt_accum_tbase.sv
module evt_accum_tbase #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/evt_accum_fsm.sv
module evt_accum_fsm
    import evt_accum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode,
    input  logic pol,
    input  logic lvl,
    input  logic rise,
    input  logic fall,
    input  logic tick,
    output logic inc,
    output logic edge_hit,
    output logic active
);
    acc_state_t state_q, state_d;
    logic       sel_edge;

    assign sel_edge = pol ? fall : rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        // transitions: DISABLE, ARM_EVENT, ARM_GATED
        if (!en)       state_d = ST_OFF;
        else if (mode) state_d = ST_GATED;
        else           state_d = ST_EVENT;

        inc      = 1'b0;
        edge_hit = 1'b0;
        active   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                active = 1'b0;
            end
            ST_EVENT: begin
                active   = 1'b1;
                inc      = sel_edge;
                edge_hit = sel_edge;
            end
            ST_GATED: begin
                active   = 1'b1;
                inc      = tick & (lvl != pol);
                edge_hit = sel_edge;
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/evt_accum.sv
module evt_accum
    import evt_accum_pkg::*;
#(
    parameter int CNT_W    = DATA_W,
    parameter int TICK_DIV = 64,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] count_q;
    logic [1:0]       flag_q;
    logic [1:0]       ien_q;

    logic lvl, rise, fall, tick;
    logic inc, edge_hit, active;
    logic wr_ctrl, wr_cnt, wr_flg, wr_ien;
    logic wrap_set;
    logic [1:0] flag_set, flag_clr;

    evt_accum_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    evt_accum_tbase #(.DIV(TICK_DIV)) u_tbase (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    evt_accum_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl_q[CTL_EN]), .mode(ctrl_q[CTL_MODE]), .pol(ctrl_q[CTL_POL]),
        .lvl(lvl), .rise(rise), .fall(fall), .tick(tick),
        .inc(inc), .edge_hit(edge_hit), .active(active)
    );

    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_cnt  = bus_we && (bus_addr == ADDR_CNT);
    assign wr_flg  = bus_we && (bus_addr == ADDR_FLG);
    assign wr_ien  = bus_we && (bus_addr == ADDR_IEN);

    assign wrap_set = inc && !wr_cnt && (count_q == CNT_MAX);
    assign flag_set = {edge_hit, wrap_set};
    assign flag_clr = wr_flg ? bus_wdata[1:0] : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
            if (wr_ien)  ien_q  <= bus_wdata[1:0];
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    // count register deliberately has no reset
    always_ff @(posedge clk) begin
        if (wr_cnt)   count_q <= bus_wdata[CNT_W-1:0];
        else if (inc) count_q <= count_q + 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {{(DATA_W-3){1'b0}}, ctrl_q};
            ADDR_CNT:  bus_rdata = DATA_W'(count_q);
            ADDR_FLG:  bus_rdata = {{(DATA_W-2){1'b0}}, flag_q};
            ADDR_IEN:  bus_rdata = {{(DATA_W-2){1'b0}}, ien_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(flag_q & ien_q);
endmodule

// File: rtl/evt_accum_chk.sv
module evt_accum_chk
    import evt_accum_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count_q,
    input logic [1:0]        flag_q,
    input logic [1:0]        ien_q,
    input logic              irq,
    input logic              inc,
    input logic              active
);
    logic cnt_wr;
    assign cnt_wr = bus_we && (bus_addr == ADDR_CNT);

    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_q == $past(bus_wdata[CNT_W-1:0])); // R10

    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)); // R3

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cnt_wr) |=> $stable(count_q)); // R5

    AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && count_q == {CNT_W{1'b1}}) |=> flag_q[FLG_WRAP]); // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 2'b00) |-> !irq); // R9
endmodule

bind evt_accum evt_accum_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count_q(count_q), .flag_q(flag_q),
    .ien_q(ien_q), .irq(irq), .inc(inc), .active(active)
);

// File: tb/evt_accum_tb.sv
module evt_accum_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    evt_accum u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ctl(input logic en, input logic gated, input logic pol);
        return {5'd0, pol, gated, en};
    endfunction

    function automatic logic edge_sel(input logic prev, input logic cur, input logic pol);
        return pol ? (prev & ~cur) : (~prev & cur);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_cnt;
        logic       prev, cur, any_edge;
        int         k;
        void'($urandom(32'd20240611));

        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 8'h00);
        rd(2'd2, d); check("R1 flags", d, 8'h00);
        rd(2'd3, d); check("R1 ien", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R5 disabled: toggles ignored
        wr(2'd1, 8'h33);
        for (int i = 0; i < 20; i++) begin @(negedge clk); pin_in = ~pin_in; end
        pin_in = 1'b0; idle(4);
        rd(2'd1, d); check("R5 count held", d, 8'h33);
        rd(2'd2, d); check("R5 no flags", d, 8'h00);

        // R3 / R7 random event mode, polarity 0 and 1
        for (int p = 0; p < 2; p++) begin
            pin_in = 1'b0; idle(4);
            wr(2'd0, ctl(1'b1, 1'b0, p[0]));
            idle(2);
            wr(2'd1, 8'h00);
            wr(2'd2, 8'h03);
            exp_cnt = 8'h00; prev = 1'b0; any_edge = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                cur = 1'($urandom % 2);
                pin_in = cur;
                if (edge_sel(prev, cur, p[0])) begin exp_cnt++; any_edge = 1'b1; end
                prev = cur;
            end
            idle(4);
            rd(2'd1, d); check(p == 0 ? "R3 rising count" : "R3 falling count", d, exp_cnt);
            rd(2'd2, d); check("R7 event edge flag", {6'd0, d[1], 1'b0}, {6'd0, any_edge, 1'b0});
        end

        // R11 full rate toggling
        pin_in = 1'b0; idle(4);
        wr(2'd0, ctl(1'b1, 1'b0, 1'b0));
        wr(2'd1, 8'h10);
        for (int i = 0; i < 20; i++) begin @(negedge clk); pin_in = ~pin_in; end
        pin_in = 1'b0; idle(4);
        rd(2'd1, d); check("R11 toggle every clock", d, 8'h1A);

        // R6 wrap flag and R9 irq
        wr(2'd2, 8'h03);
        wr(2'd1, 8'hFE);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); pin_in = 1'b1; idle(2); pin_in = 1'b0; idle(2);
        end
        idle(3);
        rd(2'd1, d); check("R6 wrapped count", d, 8'h00);
        rd(2'd2, d); check("R6 wrap flag", d, 8'h03);
        check("R9 irq off without enables", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h01);
        #1 check("R9 irq on wrap enable", {7'd0, irq}, 8'h01);
        wr(2'd3, 8'h00);
        rd(2'd2, d); check("R9 enables keep flags", d, 8'h03);
        wr(2'd3, 8'h02);
        // R8 W1C
        wr(2'd2, 8'h01);
        rd(2'd2, d); check("R8 clear wrap only", d, 8'h02);
        check("R9 irq edge", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, d); check("R8 zero write no effect", d, 8'h02);
        wr(2'd2, 8'h02);
        rd(2'd2, d); check("R8 clear edge", d, 8'h00);
        check("R9 irq drops", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h00);

        // R10 write wins over same-cycle increment at 0xFF
        wr(2'd1, 8'hFF);
        @(negedge clk); pin_in = 1'b1;
        @(negedge clk);
        wr(2'd1, 8'h40);
        pin_in = 1'b0; idle(4);
        rd(2'd1, d); check("R10 write wins", d, 8'h40);
        rd(2'd2, d); check("R10 no wrap flag", d, 8'h02);
        wr(2'd2, 8'h03);

        // R4 gated, polarity 0 (high active), random whole windows
        pin_in = 1'b0;
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0));
        idle(4);
        wr(2'd1, 8'h00);
        exp_cnt = 8'h00;
        for (int s = 0; s < 4; s++) begin
            k = 1 + int'($urandom % 3);
            @(negedge clk); pin_in = 1'b1;
            idle(64 * k - 1);
            @(negedge clk); pin_in = 1'b0;
            idle(1 + int'($urandom % 90));
            exp_cnt += 8'(k);
        end
        idle(4);
        rd(2'd1, d); check("R4 gated high-active count", d, exp_cnt);
        rd(2'd2, d); check("R7 gated edge flag", d, 8'h02);

        // R4 gated polarity 1: high inhibits, low counts
        wr(2'd0, ctl(1'b1, 1'b1, 1'b1));
        @(negedge clk); pin_in = 1'b1;
        idle(4);
        wr(2'd1, 8'h80);
        idle(300);
        rd(2'd1, d); check("R4 high inhibits", d, 8'h80);
        @(negedge clk); pin_in = 1'b0;
        idle(127);
        @(negedge clk); pin_in = 1'b1;
        idle(4);
        rd(2'd1, d); check("R4 low counts", d, 8'h82);

        // R2 count survives reset; R1 after second reset
        wr(2'd1, 8'h5A);
        pin_in = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        rd(2'd1, d); check("R2 count kept", d, 8'h5A);
        rd(2'd0, d); check("R1 ctrl after reset", d, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule